// File: doc/BRIEF.md
# Per-Strand Ordering Buffer

This block holds the cache write-backs and persist barriers of several independent strands. Each strand has its own small in-order buffer. Entries come from the persist ordering queue through one insert port, which names the target buffer. Inside a buffer, write-backs that sit ahead of every barrier may all be outstanding toward the cache at once. A write-back queued behind a barrier stays held until that barrier leaves the buffer.

One round-robin arbiter shares a single write-back request port among all buffers. The cache returns acknowledgements that carry the buffer index and the slot tag. Entries leave each buffer strictly from the oldest end. Each retirement raises a completion notice toward the queue with the tag the queue supplied on insertion. Each buffer also shows whether it is empty and where its oldest slot is, so the queue can release a pending join or take a snapshot of the heads. `DEPTH` and `NUM_BUF` must be powers of two, and `DEPTH` must be at least 2.

Top module: `strand_order_buf`

## Requirements
- R1: After reset every buffer reports drained, every head position is 0, `wb_req_valid` and all `cpl_valid` bits are low, and `ins_ready` is high.
- R2: A write-back inserted into a buffer that holds no barrier may be requested from the next cycle onward. Several write-backs of one buffer may be outstanding at once. Within a buffer the oldest eligible write-back is requested first.
- R3: A write-back that has an older barrier in its buffer is not requested before that barrier retires. It becomes requestable in the cycle that follows the barrier's retirement.
- R4: A barrier retires in the cycle it stands at the head of its buffer, that is, once every older entry has retired. Its completion notice carries the barrier's queue tag.
- R5: An acknowledgement (`wb_ack_buf`, `wb_ack_tag` equal to the slot index given with the request) marks that write-back complete. A completed write-back retires only at the head, so retirement stays in insertion order even when acknowledgements arrive out of order.
- R6: On each retirement `cpl_valid[b]` is high for one cycle, and `cpl_qtag` field b (bits b*QTAG_W upward) holds the entry's queue tag.
- R7: At most one write-back request is presented per cycle. The request rotates round-robin over buffers, starting after the last buffer granted, and buffer 0 is first after reset. A request that is not accepted keeps its buffer, tag and address until `wb_req_ready` is high.
- R8: `drained[b]` is high exactly when buffer b holds no entry.
- R9: `head_pos` field b (bits b*PTR_W upward) gives the slot of buffer b's oldest entry. It advances by one, modulo DEPTH, on each retirement and holds otherwise.
- R10: `ins_ready` is low exactly when the buffer selected by `ins_buf` holds DEPTH entries.
- R11: A barrier in one buffer does not hold write-backs of any other buffer.
- R12: A write-back inserted in the same cycle that its buffer's only barrier retires is requestable from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ins_valid | input | 1 | Insert an entry |
| ins_buf | input | $clog2(NUM_BUF) | Target buffer of the insert |
| ins_barrier | input | 1 | 1 = barrier, 0 = write-back |
| ins_addr | input | ADDR_W | Cache line address of a write-back |
| ins_qtag | input | QTAG_W | Queue tag returned on completion |
| ins_ready | output | 1 | Selected buffer has a free slot |
| wb_req_valid | output | 1 | Write-back request to the cache |
| wb_req_ready | input | 1 | Cache accepts the request |
| wb_req_buf | output | $clog2(NUM_BUF) | Buffer of the request |
| wb_req_tag | output | $clog2(DEPTH) | Slot index of the request |
| wb_req_addr | output | ADDR_W | Line address of the request |
| wb_ack_valid | input | 1 | Cache acknowledgement that a line is persistent |
| wb_ack_buf | input | $clog2(NUM_BUF) | Buffer of the acknowledged write-back |
| wb_ack_tag | input | $clog2(DEPTH) | Slot of the acknowledged write-back |
| cpl_valid | output | NUM_BUF | Per-buffer retirement notice |
| cpl_qtag | output | NUM_BUF*QTAG_W | Per-buffer queue tag of the retiring entry |
| drained | output | NUM_BUF | Per-buffer empty flag |
| head_pos | output | NUM_BUF*$clog2(DEPTH) | Per-buffer oldest slot index |

## Verification
The bench acknowledges write-backs out of order and expects completions in insertion order. A design that retired on acknowledgement would report the younger tag first. It places a write-back behind a barrier that itself waits on an older write-back, and expects two silent cycles before the release. A design that released early would show the held address too soon. It inserts a write-back in the very cycle the only barrier retires; a design that counted the retiring barrier would block that write-back forever. It also fills a buffer to DEPTH, checks that ready drops only for that buffer, and wraps the head position. Finally, it loads two buffers with ready held low to check that requests rotate between buffers and stay steady while stalled; a fixed-priority arbiter would serve one buffer twice in a row.

// File: rtl/sob_pkg.sv
package sob_pkg;
  typedef struct packed {
    logic valid;
    logic barrier;
    logic can_issue;
    logic issued;
    logic completed;
  } sob_flags_t;
endpackage

// File: rtl/sob_rr_arb.sv
module sob_rr_arb #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          ready,
  output logic          valid,
  output logic [IW-1:0] sel
);
  logic [IW-1:0] ptr_q, ptr_d, lk_idx_q, lk_idx_d, pick;
  logic          lk_q, lk_d;

  always_comb begin
    int c;
    c    = 0;
    pick = ptr_q;
    for (int k = N; k >= 1; k--) begin
      c = (int'(ptr_q) + k) % N;
      if (req[c]) pick = IW'(c);
    end
    valid = |req;
    sel   = lk_q ? lk_idx_q : pick;
  end

  always_comb begin
    ptr_d    = ptr_q;
    lk_d     = lk_q;
    lk_idx_d = lk_idx_q;
    if (valid && ready) begin
      ptr_d = sel;
      lk_d  = 1'b0;
    end else if (valid) begin
      lk_d     = 1'b1;
      lk_idx_d = sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= IW'(N - 1);
      lk_q     <= 1'b0;
      lk_idx_q <= '0;
    end else begin
      ptr_q    <= ptr_d;
      lk_q     <= lk_d;
      lk_idx_q <= lk_idx_d;
    end
  end
endmodule

// File: rtl/sob_lane.sv
module sob_lane #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int QTAG_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ins_en,
  input  logic                       ins_bar,
  input  logic [ADDR_W-1:0]          ins_addr,
  input  logic [QTAG_W-1:0]          ins_qtag,
  input  logic                       ack_en,
  input  logic [$clog2(DEPTH)-1:0]   ack_idx,
  input  logic                       issue_grant,
  output logic                       cand_valid,
  output logic [$clog2(DEPTH)-1:0]   cand_idx,
  output logic [ADDR_W-1:0]          cand_addr,
  output logic                       cpl_valid,
  output logic [QTAG_W-1:0]          cpl_qtag,
  output logic                       full,
  output logic                       drained,
  output logic [$clog2(DEPTH)-1:0]   head
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  sob_pkg::sob_flags_t fl_q [DEPTH];
  sob_pkg::sob_flags_t fl_d [DEPTH];
  logic [ADDR_W-1:0]   addr_q [DEPTH];
  logic [QTAG_W-1:0]   qtag_q [DEPTH];
  logic [PTR_W-1:0]    head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;

  logic                retire;
  logic                any_bar;
  logic [DEPTH-1:0]    bar_eff;
  logic [DEPTH-1:0]    blocked;
  logic [PTR_W-1:0]    off [DEPTH];

  // oldest entry leaves when it is a barrier or has been acknowledged
  assign retire = fl_q[head_q].valid && (fl_q[head_q].barrier || fl_q[head_q].completed);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      off[i]     = PTR_W'(i) - head_q;
      bar_eff[i] = fl_q[i].valid && fl_q[i].barrier && !(retire && (PTR_W'(i) == head_q));
    end
    any_bar = |bar_eff;
    for (int i = 0; i < DEPTH; i++) begin
      blocked[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (bar_eff[j] && (off[j] < off[i])) blocked[i] = 1'b1;
      end
    end
  end

  // oldest eligible write-back in age order
  always_comb begin
    logic [PTR_W-1:0] idx;
    idx        = '0;
    cand_valid = 1'b0;
    cand_idx   = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      idx = head_q + PTR_W'(k);
      if (fl_q[idx].valid && !fl_q[idx].barrier && fl_q[idx].can_issue && !fl_q[idx].issued) begin
        cand_valid = 1'b1;
        cand_idx   = idx;
      end
    end
  end

  assign cand_addr = addr_q[cand_idx];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      fl_d[i] = fl_q[i];
      if (fl_q[i].valid && !fl_q[i].barrier && !blocked[i]) fl_d[i].can_issue = 1'b1;
      if (issue_grant && (cand_idx == PTR_W'(i))) fl_d[i].issued = 1'b1;
      if (ack_en && (ack_idx == PTR_W'(i)) && fl_q[i].valid && fl_q[i].issued)
        fl_d[i].completed = 1'b1;
    end
    if (retire) fl_d[head_q] = '0;
    if (ins_en) begin
      fl_d[tail_q].valid     = 1'b1;
      fl_d[tail_q].barrier   = ins_bar;
      fl_d[tail_q].can_issue = !ins_bar && !any_bar;
      fl_d[tail_q].issued    = 1'b0;
      fl_d[tail_q].completed = 1'b0;
    end
    head_d = head_q + PTR_W'(retire);
    tail_d = tail_q + PTR_W'(ins_en);
    cnt_d  = cnt_q + CNT_W'(ins_en) - CNT_W'(retire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) fl_q[i] <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) fl_q[i] <= fl_d[i];
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  // payload storage, written only on insert
  always_ff @(posedge clk) begin
    if (ins_en) begin
      addr_q[tail_q] <= ins_addr;
      qtag_q[tail_q] <= ins_qtag;
    end
  end

  assign cpl_valid = retire;
  assign cpl_qtag  = qtag_q[head_q];
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign drained   = (cnt_q == '0);
  assign head      = head_q;
endmodule

// File: rtl/strand_order_buf.sv
module strand_order_buf #(
  parameter int NUM_BUF = 4,
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 16,
  parameter int QTAG_W  = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               ins_valid,
  input  logic [$clog2(NUM_BUF)-1:0]         ins_buf,
  input  logic                               ins_barrier,
  input  logic [ADDR_W-1:0]                  ins_addr,
  input  logic [QTAG_W-1:0]                  ins_qtag,
  output logic                               ins_ready,
  output logic                               wb_req_valid,
  input  logic                               wb_req_ready,
  output logic [$clog2(NUM_BUF)-1:0]         wb_req_buf,
  output logic [$clog2(DEPTH)-1:0]           wb_req_tag,
  output logic [ADDR_W-1:0]                  wb_req_addr,
  input  logic                               wb_ack_valid,
  input  logic [$clog2(NUM_BUF)-1:0]         wb_ack_buf,
  input  logic [$clog2(DEPTH)-1:0]           wb_ack_tag,
  output logic [NUM_BUF-1:0]                 cpl_valid,
  output logic [NUM_BUF*QTAG_W-1:0]          cpl_qtag,
  output logic [NUM_BUF-1:0]                 drained,
  output logic [NUM_BUF*$clog2(DEPTH)-1:0]   head_pos
);
  localparam int BI_W  = $clog2(NUM_BUF);
  localparam int PTR_W = $clog2(DEPTH);

  logic [1:0]         rst_sync_q;
  logic               core_rst_n;
  logic [NUM_BUF-1:0] full;
  logic [NUM_BUF-1:0] cand_valid;
  logic [PTR_W-1:0]   cand_idx  [NUM_BUF];
  logic [ADDR_W-1:0]  cand_addr [NUM_BUF];
  logic [BI_W-1:0]    sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  assign ins_ready = !full[ins_buf];

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_lane
    logic ins_en_b, ack_en_b, grant_b;
    assign ins_en_b = ins_valid && ins_ready && (ins_buf == BI_W'(b));
    assign ack_en_b = wb_ack_valid && (wb_ack_buf == BI_W'(b));
    assign grant_b  = wb_req_valid && wb_req_ready && (sel == BI_W'(b));

    sob_lane #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .QTAG_W(QTAG_W)) lane_i (
      .clk         (clk),
      .rst_n       (core_rst_n),
      .ins_en      (ins_en_b),
      .ins_bar     (ins_barrier),
      .ins_addr    (ins_addr),
      .ins_qtag    (ins_qtag),
      .ack_en      (ack_en_b),
      .ack_idx     (wb_ack_tag),
      .issue_grant (grant_b),
      .cand_valid  (cand_valid[b]),
      .cand_idx    (cand_idx[b]),
      .cand_addr   (cand_addr[b]),
      .cpl_valid   (cpl_valid[b]),
      .cpl_qtag    (cpl_qtag[b*QTAG_W +: QTAG_W]),
      .full        (full[b]),
      .drained     (drained[b]),
      .head        (head_pos[b*PTR_W +: PTR_W])
    );
  end

  sob_rr_arb #(.N(NUM_BUF)) arb_i (
    .clk   (clk),
    .rst_n (core_rst_n),
    .req   (cand_valid),
    .ready (wb_req_ready),
    .valid (wb_req_valid),
    .sel   (sel)
  );

  assign wb_req_buf  = sel;
  assign wb_req_tag  = cand_idx[sel];
  assign wb_req_addr = cand_addr[sel];
endmodule

// File: rtl/sob_chk.sv
module sob_chk #(
  parameter int NUM_BUF = 4,
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 16,
  parameter int QTAG_W  = 4
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [$clog2(NUM_BUF)-1:0]         ins_buf,
  input logic                               ins_ready,
  input logic                               wb_req_valid,
  input logic                               wb_req_ready,
  input logic [$clog2(NUM_BUF)-1:0]         wb_req_buf,
  input logic [$clog2(DEPTH)-1:0]           wb_req_tag,
  input logic [ADDR_W-1:0]                  wb_req_addr,
  input logic [NUM_BUF-1:0]                 cpl_valid,
  input logic [NUM_BUF-1:0]                 drained,
  input logic [NUM_BUF*$clog2(DEPTH)-1:0]   head_pos
);
  localparam int PTR_W = $clog2(DEPTH);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req_valid && !wb_req_ready) |=>
      (wb_req_valid && $stable(wb_req_buf) && $stable(wb_req_tag) && $stable(wb_req_addr)));

  // R10
  full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_ready |-> !drained[ins_buf]);

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    // R8
    empty_no_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drained[b] |-> !cpl_valid[b]);

    // R9
    head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid[b] |=> (head_pos[b*PTR_W +: PTR_W] == $past(head_pos[b*PTR_W +: PTR_W]) + PTR_W'(1)));

    // R9
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpl_valid[b] |=> $stable(head_pos[b*PTR_W +: PTR_W]));
  end
endmodule

bind strand_order_buf sob_chk #(
  .NUM_BUF (NUM_BUF),
  .DEPTH   (DEPTH),
  .ADDR_W  (ADDR_W),
  .QTAG_W  (QTAG_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .ins_buf      (ins_buf),
  .ins_ready    (ins_ready),
  .wb_req_valid (wb_req_valid),
  .wb_req_ready (wb_req_ready),
  .wb_req_buf   (wb_req_buf),
  .wb_req_tag   (wb_req_tag),
  .wb_req_addr  (wb_req_addr),
  .cpl_valid    (cpl_valid),
  .drained      (drained),
  .head_pos     (head_pos)
);

// File: tb/strand_order_buf_tb_top.sv
module strand_order_buf_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ins_valid, ins_barrier, ins_ready;
  logic [1:0]  ins_buf;
  logic [15:0] ins_addr;
  logic [3:0]  ins_qtag;
  logic        wb_req_valid, wb_req_ready;
  logic [1:0]  wb_req_buf;
  logic [2:0]  wb_req_tag;
  logic [15:0] wb_req_addr;
  logic        wb_ack_valid;
  logic [1:0]  wb_ack_buf;
  logic [2:0]  wb_ack_tag;
  logic [3:0]  cpl_valid;
  logic [15:0] cpl_qtag;
  logic [3:0]  drained;
  logic [11:0] head_pos;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  strand_order_buf dut_i (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_buf(ins_buf), .ins_barrier(ins_barrier),
    .ins_addr(ins_addr), .ins_qtag(ins_qtag), .ins_ready(ins_ready),
    .wb_req_valid(wb_req_valid), .wb_req_ready(wb_req_ready), .wb_req_buf(wb_req_buf),
    .wb_req_tag(wb_req_tag), .wb_req_addr(wb_req_addr),
    .wb_ack_valid(wb_ack_valid), .wb_ack_buf(wb_ack_buf), .wb_ack_tag(wb_ack_tag),
    .cpl_valid(cpl_valid), .cpl_qtag(cpl_qtag), .drained(drained), .head_pos(head_pos)
  );

  typedef struct packed {
    logic        iv;  logic ib; logic [15:0] ia; logic [3:0] iq;
    logic        av;  logic [2:0] at;
    logic        erv; logic [15:0] era; logic [2:0] ert;
    logic        ecv; logic [3:0] ecq;
    logic        edr;
  } vec_t;

  // buffer 0: two write-backs, barrier, held write-back, out-of-order acks
  localparam vec_t TBL [13] = '{
    '{1'b1, 1'b0, 16'h0010, 4'd1, 1'b0, 3'd0, 1'b0, 16'h0000, 3'd0, 1'b0, 4'd0, 1'b1},
    '{1'b1, 1'b0, 16'h0020, 4'd2, 1'b0, 3'd0, 1'b1, 16'h0010, 3'd0, 1'b0, 4'd0, 1'b0},
    '{1'b1, 1'b1, 16'h0000, 4'd3, 1'b0, 3'd0, 1'b1, 16'h0020, 3'd1, 1'b0, 4'd0, 1'b0},
    '{1'b1, 1'b0, 16'h0030, 4'd4, 1'b0, 3'd0, 1'b0, 16'h0000, 3'd0, 1'b0, 4'd0, 1'b0},
    '{1'b0, 1'b0, 16'h0000, 4'd0, 1'b1, 3'd1, 1'b0, 16'h0000, 3'd0, 1'b0, 4'd0, 1'b0},
    '{1'b0, 1'b0, 16'h0000, 4'd0, 1'b1, 3'd0, 1'b0, 16'h0000, 3'd0, 1'b0, 4'd0, 1'b0},
    '{1'b0, 1'b0, 16'h0000, 4'd0, 1'b0, 3'd0, 1'b0, 16'h0000, 3'd0, 1'b1, 4'd1, 1'b0},
    '{1'b0, 1'b0, 16'h0000, 4'd0, 1'b0, 3'd0, 1'b0, 16'h0000, 3'd0, 1'b1, 4'd2, 1'b0},
    '{1'b0, 1'b0, 16'h0000, 4'd0, 1'b0, 3'd0, 1'b0, 16'h0000, 3'd0, 1'b1, 4'd3, 1'b0},
    '{1'b0, 1'b0, 16'h0000, 4'd0, 1'b0, 3'd0, 1'b1, 16'h0030, 3'd3, 1'b0, 4'd0, 1'b0},
    '{1'b0, 1'b0, 16'h0000, 4'd0, 1'b1, 3'd3, 1'b0, 16'h0000, 3'd0, 1'b0, 4'd0, 1'b0},
    '{1'b0, 1'b0, 16'h0000, 4'd0, 1'b0, 3'd0, 1'b0, 16'h0000, 3'd0, 1'b1, 4'd4, 1'b0},
    '{1'b0, 1'b0, 16'h0000, 4'd0, 1'b0, 3'd0, 1'b0, 16'h0000, 3'd0, 1'b0, 4'd0, 1'b1}
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic idle();
    @(negedge clk);
    ins_valid    = 1'b0;
    wb_ack_valid = 1'b0;
  endtask

  task automatic ins(input logic [1:0] b, input logic bar, input logic [15:0] a, input logic [3:0] q);
    @(negedge clk);
    ins_valid = 1'b1; ins_buf = b; ins_barrier = bar; ins_addr = a; ins_qtag = q;
    wb_ack_valid = 1'b0;
  endtask

  task automatic ack(input logic [1:0] b, input logic [2:0] t);
    @(negedge clk);
    ins_valid = 1'b0;
    wb_ack_valid = 1'b1; wb_ack_buf = b; wb_ack_tag = t;
  endtask

  task automatic check_req(input string rq, input logic [1:0] b, input logic [15:0] a, input logic [2:0] t);
    check({rq, " req valid"}, {31'd0, wb_req_valid}, 32'd1);
    check({rq, " req buf"},   {30'd0, wb_req_buf}, {30'd0, b});
    check({rq, " req addr"},  {16'd0, wb_req_addr}, {16'd0, a});
    check({rq, " req tag"},   {29'd0, wb_req_tag}, {29'd0, t});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; ins_valid = 1'b0; ins_buf = '0; ins_barrier = 1'b0; ins_addr = '0;
    ins_qtag = '0; wb_req_ready = 1'b0; wb_ack_valid = 1'b0; wb_ack_buf = '0; wb_ack_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 drained", {28'd0, drained}, 32'hf);
    check("R1 head_pos", {20'd0, head_pos}, 32'd0);
    check("R1 req_valid", {31'd0, wb_req_valid}, 32'd0);
    check("R1 cpl_valid", {28'd0, cpl_valid}, 32'd0);
    check("R1 ins_ready", {31'd0, ins_ready}, 32'd1);

    // table walk on buffer 0: R2 R3 R4 R5 R6 R8
    wb_req_ready = 1'b1;
    for (int i = 0; i < 13; i++) begin
      vec_t v;
      v = TBL[i];
      @(negedge clk);
      check($sformatf("R2/R3 row%0d req_valid", i), {31'd0, wb_req_valid}, {31'd0, v.erv});
      if (v.erv) begin
        check($sformatf("R2 row%0d req addr", i), {16'd0, wb_req_addr}, {16'd0, v.era});
        check($sformatf("R2 row%0d req tag", i), {29'd0, wb_req_tag}, {29'd0, v.ert});
      end
      check($sformatf("R5/R4 row%0d cpl_valid", i), {31'd0, cpl_valid[0]}, {31'd0, v.ecv});
      if (v.ecv) check($sformatf("R6 row%0d cpl_qtag", i), {28'd0, cpl_qtag[3:0]}, {28'd0, v.ecq});
      check($sformatf("R8 row%0d drained", i), {31'd0, drained[0]}, {31'd0, v.edr});
      ins_valid = v.iv; ins_buf = 2'd0; ins_barrier = v.ib; ins_addr = v.ia; ins_qtag = v.iq;
      wb_ack_valid = v.av; wb_ack_buf = 2'd0; wb_ack_tag = v.at;
    end
    idle();
    check("R9 head0 after four retirements", {29'd0, head_pos[2:0]}, 32'd4);

    // R7 round-robin and hold while stalled
    wb_req_ready = 1'b0;
    ins(2'd1, 1'b0, 16'h0100, 4'd5);
    ins(2'd1, 1'b0, 16'h0110, 4'd6);
    ins(2'd2, 1'b0, 16'h0200, 4'd7);
    idle();
    check_req("R7 first", 2'd1, 16'h0100, 3'd0);
    idle();
    check_req("R7 held", 2'd1, 16'h0100, 3'd0);
    wb_req_ready = 1'b1;
    idle();
    check_req("R7 rotate", 2'd2, 16'h0200, 3'd0);
    idle();
    check_req("R7 back", 2'd1, 16'h0110, 3'd1);
    idle();
    check("R7 none left", {31'd0, wb_req_valid}, 32'd0);
    ack(2'd1, 3'd0); ack(2'd1, 3'd1); ack(2'd2, 3'd0);
    idle(); idle(); idle();
    check("R8 drained1", {31'd0, drained[1]}, 32'd1);
    check("R8 drained2", {31'd0, drained[2]}, 32'd1);

    // R11 independence and R3 release timing
    wb_req_ready = 1'b0;
    ins(2'd1, 1'b0, 16'h0300, 4'd8);
    ins(2'd1, 1'b1, 16'h0000, 4'd9);
    ins(2'd1, 1'b0, 16'h0310, 4'd10);
    ins(2'd2, 1'b0, 16'h0400, 4'd11);
    idle();
    check_req("R2 buf1 oldest", 2'd1, 16'h0300, 3'd2);
    wb_req_ready = 1'b1;
    idle();
    check_req("R11 other buffer not held", 2'd2, 16'h0400, 3'd1);
    idle();
    check("R3 held behind barrier", {31'd0, wb_req_valid}, 32'd0);
    ack(2'd1, 3'd2);
    idle();
    check("R5 cpl after ack", {31'd0, cpl_valid[1]}, 32'd1);
    check("R6 qtag write-back", {28'd0, cpl_qtag[7:4]}, 32'd8);
    check("R3 still held", {31'd0, wb_req_valid}, 32'd0);
    idle();
    check("R4 barrier cpl", {31'd0, cpl_valid[1]}, 32'd1);
    check("R4 barrier qtag", {28'd0, cpl_qtag[7:4]}, 32'd9);
    check("R3 held during barrier retire", {31'd0, wb_req_valid}, 32'd0);
    idle();
    check_req("R3 released", 2'd1, 16'h0310, 3'd4);
    ack(2'd1, 3'd4); ack(2'd2, 3'd1);
    idle(); idle(); idle();
    check("R8 drained1 again", {31'd0, drained[1]}, 32'd1);
    check("R8 drained2 again", {31'd0, drained[2]}, 32'd1);

    // R12 insert while the only barrier retires
    ins(2'd3, 1'b1, 16'h0000, 4'd12);
    ins(2'd3, 1'b0, 16'h0500, 4'd13);
    check("R4 lone barrier cpl", {31'd0, cpl_valid[3]}, 32'd1);
    check("R6 lone barrier qtag", {28'd0, cpl_qtag[15:12]}, 32'd12);
    idle();
    check_req("R12 eligible", 2'd3, 16'h0500, 3'd1);
    ack(2'd3, 3'd1);
    idle(); idle();
    check("R8 drained3", {31'd0, drained[3]}, 32'd1);

    // R10 full buffer, R9 wrap
    wb_req_ready = 1'b0;
    for (int k = 0; k < 8; k++) ins(2'd3, 1'b0, 16'h0600 + 16'(k), 4'(k));
    idle();
    ins_buf = 2'd3;
    #1 check("R10 ready low for full buffer", {31'd0, ins_ready}, 32'd0);
    ins_buf = 2'd2;
    #1 check("R10 ready high for other buffer", {31'd0, ins_ready}, 32'd1);
    check("R8 full not drained", {31'd0, drained[3]}, 32'd0);
    check("R9 head3", {29'd0, head_pos[11:9]}, 32'd2);
    check_req("R2 full oldest first", 2'd3, 16'h0600, 3'd2);
    wb_req_ready = 1'b1;
    repeat (8) idle();
    for (int t = 0; t < 8; t++) ack(2'd3, 3'(t));
    repeat (12) idle();
    check("R8 drained3 after full", {31'd0, drained[3]}, 32'd1);
    check("R9 head3 wrapped", {29'd0, head_pos[11:9]}, 32'd2);
    check("R9 head1", {29'd0, head_pos[5:3]}, 32'd5);

    summary();
    $finish;
  end
endmodule